// File: doc/BRIEF.md
# Shared Memory Time-Slot Arbiter

This block decides, on every memory clock slot, which agent owns a single memory shared by video and system traffic. Ownership does not come from request priority. It comes from a fixed slot pattern set by the horizontal slot position, the scan line and the display mode. Odd slots near the start of each line go to memory refresh, then to sound and then to sprite fetches. Inside the display fetch window, bitplane fetches follow an 8-slot group pattern. In low resolution with at most four planes, or high resolution with at most two, that pattern uses only odd slots. With more planes it also takes even slots. The processor is given any slot that no DMA source claims.

The processor presents a request together with an address. An address below the shared-memory limit must wait for a free slot. Its acknowledge is held back until that slot is granted. Any other address, for example expansion memory or ROM, is acknowledged at once and never competes with DMA. Each decision is registered: the owner vector and the acknowledge for a slot value show up one clock after that value is presented on the counter inputs.

The processor side is a three-state machine. `S_IDLE` means no request is pending. `S_WAIT` means a shared-memory request is blocked by DMA. `S_ACK` is the single cycle in which the acknowledge is high. The transitions are as follows. `S_IDLE` goes to `S_ACK` when a non-shared request arrives, or when a shared request arrives in a free slot. `S_IDLE` goes to `S_WAIT` when a shared request arrives in a DMA slot. `S_WAIT` goes to `S_ACK` when a free slot comes, and back to `S_IDLE` if the request is dropped. `S_ACK` always returns to `S_IDLE` and accepts nothing in that cycle.

Top module: `memslot_arbiter`

## Requirements
- R1: `slot_owner` bits are [0] refresh, [1] sound, [2] sprite, [3] bitplane, [4] processor. At most one bit is set, the vector is zero for an idle slot, and it reflects the slot value presented one clock earlier.
- R2: Refresh owns odd slots 1, 3, 5 and 7 of every line, whatever the enables, line or mode.
- R3: Sound owns odd slots 9 to 15 when `snd_en` is 1, and sprites own odd slots 17 to 31 when `spr_en` is 1. When an enable is 0, its slots are idle.
- R4: Bitplane fetches happen only when `plane_en` is 1, on lines 26 to 226 and in slots 56 to 215. Lines 0 to 25 and 227 to 262 (62 blanking lines) and slots outside that range carry no bitplane fetch.
- R5: Low resolution (`hires`=0). Let pos = (slot-56) mod 8. Plane 1 is at pos 1, plane 2 at pos 3, plane 3 at pos 5, plane 4 at pos 7, plane 5 at pos 2 and plane 6 at pos 6. A slot is a bitplane slot when its plane number is at most `plane_cnt`, and a count of 7 acts as 6.
- R6: High resolution (`hires`=1). Plane 1 is at pos 1 and 5, plane 2 at pos 3 and 7, plane 3 at pos 0 and 4, and plane 4 at pos 2 and 6. Counts above 4 act as 4.
- R7: A processor request with `cpu_addr` below 0x080000 is granted in the first presented slot that no DMA claims. `cpu_ack` then pulses for one cycle, together with `slot_owner[4]`.
- R8: While DMA claims the presented slots, a held shared-memory request gets no acknowledge and the DMA source keeps the slot.
- R9: A request with `cpu_addr` at or above 0x080000 is acknowledged one clock after it is presented, even in a DMA slot, and `slot_owner[4]` stays 0.
- R10: No request is accepted in the acknowledge cycle. `cpu_ack` is never high for two cycles in a row, and a held request is granted again no earlier than two cycles later.
- R11: While `rst_n` is low, `slot_owner` and `cpu_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_cnt | input | 8 | Horizontal slot position within the line |
| line_cnt | input | 9 | Scan line number within the frame |
| plane_cnt | input | 3 | Number of enabled bitplanes |
| hires | input | 1 | 1 selects high-resolution fetch pattern |
| snd_en | input | 1 | Sound DMA enable |
| spr_en | input | 1 | Sprite DMA enable |
| plane_en | input | 1 | Bitplane DMA enable |
| cpu_req | input | 1 | Processor access request, held until acknowledged |
| cpu_addr | input | 24 | Processor access address |
| slot_owner | output | 5 | One-hot owner of the previous slot |
| cpu_ack | output | 1 | One-cycle processor acknowledge |

## Verification
Every result is due exactly one clock after its inputs are presented. The owner vector and the acknowledge both come from registers loaded at the edge that samples the slot and line counters. The bench changes its inputs 1 ns after a rising edge, waits for the next rising edge and samples 1 ns later, so each check sees the decision for the slot just presented. Processor sequences are checked slot by slot: blocked slots show no acknowledge, the first free slot shows it, and the slot after a grant is checked for the refusal state.

// File: rtl/sa_pkg.sv
package sa_pkg;
    localparam int OWN_W   = 5;
    localparam int OWN_REF = 0;
    localparam int OWN_SND = 1;
    localparam int OWN_SPR = 2;
    localparam int OWN_BPL = 3;
    localparam int OWN_CPU = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_ACK  = 2'd2
    } cpu_state_t;

    // Plane number fetched at a group position; 0 means no plane there.
    function automatic logic [2:0] plane_at(input logic [2:0] pos, input logic hi);
        logic [2:0] p;
        if (hi) begin
            unique case (pos)
                3'd1, 3'd5: p = 3'd1;
                3'd3, 3'd7: p = 3'd2;
                3'd0, 3'd4: p = 3'd3;
                default:    p = 3'd4;
            endcase
        end else begin
            unique case (pos)
                3'd1:    p = 3'd1;
                3'd3:    p = 3'd2;
                3'd5:    p = 3'd3;
                3'd7:    p = 3'd4;
                3'd2:    p = 3'd5;
                3'd6:    p = 3'd6;
                default: p = 3'd0;
            endcase
        end
        return p;
    endfunction
endpackage

// File: rtl/sa_fixed_dma.sv
module sa_fixed_dma #(
    parameter int SLOT_W      = 8,
    parameter int REF_SLOTS   = 4,
    parameter int SND_SLOTS   = 4,
    parameter int SPR_SLOTS   = 8
) (
    input  logic [SLOT_W-1:0] slot,
    output logic              ref_hit,
    output logic              snd_hit,
    output logic              spr_hit
);
    localparam logic [SLOT_W-2:0] REF_END = (SLOT_W-1)'(REF_SLOTS);
    localparam logic [SLOT_W-2:0] SND_END = (SLOT_W-1)'(REF_SLOTS + SND_SLOTS);
    localparam logic [SLOT_W-2:0] SPR_END = (SLOT_W-1)'(REF_SLOTS + SND_SLOTS + SPR_SLOTS);

    logic [SLOT_W-2:0] odd_idx;

    always_comb begin
        odd_idx = slot[SLOT_W-1:1];
        ref_hit = slot[0] && (odd_idx < REF_END);
        snd_hit = slot[0] && !ref_hit && (odd_idx < SND_END);
        spr_hit = slot[0] && !ref_hit && !snd_hit && (odd_idx < SPR_END);
    end
endmodule

// File: rtl/sa_bpl_fetch.sv
module sa_bpl_fetch
    import sa_pkg::*;
#(
    parameter int SLOT_W     = 8,
    parameter int LINE_W     = 9,
    parameter int FIRST_LINE = 26,
    parameter int LAST_LINE  = 226,
    parameter int FIRST_SLOT = 56,
    parameter int LAST_SLOT  = 215
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [LINE_W-1:0] line,
    input  logic [2:0]        planes,
    input  logic              hi,
    input  logic              en,
    output logic              bpl_hit
);
    localparam logic [SLOT_W-1:0] FS = SLOT_W'(FIRST_SLOT);
    localparam logic [SLOT_W-1:0] LS = SLOT_W'(LAST_SLOT);
    localparam logic [LINE_W-1:0] FL = LINE_W'(FIRST_LINE);
    localparam logic [LINE_W-1:0] LL = LINE_W'(LAST_LINE);

    logic              in_win;
    logic [SLOT_W-1:0] rel;
    logic [2:0]        plane;

    always_comb begin
        in_win  = (slot >= FS) && (slot <= LS) && (line >= FL) && (line <= LL);
        rel     = slot - FS;
        plane   = plane_at(rel[2:0], hi);
        bpl_hit = en && in_win && (plane != 3'd0) && (plane <= planes);
    end
endmodule

// File: rtl/sa_cpu_fsm.sv
module sa_cpu_fsm
    import sa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic shared,
    input  logic dma_busy,
    output logic grant_mem,
    output logic ack
);
    cpu_state_t state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n   = state_q;
        grant_mem = 1'b0;
        unique case (state_q)
            S_IDLE, S_WAIT: begin
                if (!req) begin
                    state_n = S_IDLE;
                end else if (!shared) begin
                    state_n = S_ACK;
                end else if (!dma_busy) begin
                    state_n   = S_ACK;
                    grant_mem = 1'b1;
                end else begin
                    state_n = S_WAIT;
                end
            end
            S_ACK:   state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    assign ack = (state_q == S_ACK);

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R9
    ext_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_ACK && req && !shared) |=> ack);
endmodule

// File: rtl/memslot_arbiter.sv
module memslot_arbiter
    import sa_pkg::*;
#(
    parameter int SLOTS_PER_LINE  = 227,
    parameter int LINES_PER_FRAME = 263,
    parameter int DISP_FIRST_LINE = 26,
    parameter int DISP_LAST_LINE  = 226,
    parameter int FETCH_FIRST     = 56,
    parameter int FETCH_LAST      = 215,
    parameter int REF_SLOTS       = 4,
    parameter int SND_SLOTS       = 4,
    parameter int SPR_SLOTS       = 8,
    parameter int ADDR_W          = 24,
    parameter int SHARED_LIMIT    = 'h080000,
    localparam int SLOT_W         = $clog2(SLOTS_PER_LINE),
    localparam int LINE_W         = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_cnt,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [2:0]        plane_cnt,
    input  logic              hires,
    input  logic              snd_en,
    input  logic              spr_en,
    input  logic              plane_en,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [4:0]        slot_owner,
    output logic              cpu_ack
);
    localparam logic [ADDR_W-1:0] LIMIT   = ADDR_W'(SHARED_LIMIT);
    localparam logic [SLOT_W-1:0] REF_END = SLOT_W'(2 * REF_SLOTS);

    logic ref_hit, snd_hit, spr_hit, bpl_hit;
    logic dma_busy, shared, grant_mem;
    logic [OWN_W-1:0] owner_n, owner_q;

    sa_fixed_dma #(
        .SLOT_W(SLOT_W), .REF_SLOTS(REF_SLOTS),
        .SND_SLOTS(SND_SLOTS), .SPR_SLOTS(SPR_SLOTS)
    ) u_fixed (
        .slot(slot_cnt), .ref_hit(ref_hit), .snd_hit(snd_hit), .spr_hit(spr_hit)
    );

    sa_bpl_fetch #(
        .SLOT_W(SLOT_W), .LINE_W(LINE_W),
        .FIRST_LINE(DISP_FIRST_LINE), .LAST_LINE(DISP_LAST_LINE),
        .FIRST_SLOT(FETCH_FIRST), .LAST_SLOT(FETCH_LAST)
    ) u_bpl (
        .slot(slot_cnt), .line(line_cnt), .planes(plane_cnt),
        .hi(hires), .en(plane_en), .bpl_hit(bpl_hit)
    );

    assign shared   = (cpu_addr < LIMIT);
    assign dma_busy = ref_hit | (snd_hit & snd_en) | (spr_hit & spr_en) | bpl_hit;

    sa_cpu_fsm u_cpu (
        .clk(clk), .rst_n(rst_n), .req(cpu_req), .shared(shared),
        .dma_busy(dma_busy), .grant_mem(grant_mem), .ack(cpu_ack)
    );

    // Fixed channels first, then bitplanes, then the processor.
    always_comb begin
        owner_n = '0;
        if (ref_hit)                owner_n[OWN_REF] = 1'b1;
        else if (snd_hit && snd_en) owner_n[OWN_SND] = 1'b1;
        else if (spr_hit && spr_en) owner_n[OWN_SPR] = 1'b1;
        else if (bpl_hit)           owner_n[OWN_BPL] = 1'b1;
        else if (grant_mem)         owner_n[OWN_CPU] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owner_q <= '0;
        else        owner_q <= owner_n;
    end

    assign slot_owner = owner_q;

    // R1
    owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_owner));
    // R2
    refresh_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_owner[OWN_REF] |-> ($past(slot_cnt) < REF_END));
    // R3
    fixed_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_owner[OWN_REF] | slot_owner[OWN_SND] | slot_owner[OWN_SPR]) |-> $past(slot_cnt[0]));
    // R7
    cpu_slot_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_owner[OWN_CPU] |-> cpu_ack);
endmodule

// File: tb/test_memslot_arbiter.sv
`timescale 1ns/1ps
module test_memslot_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] slot_cnt = '0;
    logic [8:0] line_cnt = '0;
    logic [2:0] plane_cnt = '0;
    logic       hires = 1'b0, snd_en = 1'b0, spr_en = 1'b0, plane_en = 1'b0;
    logic       cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [4:0] slot_owner;
    logic       cpu_ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    memslot_arbiter i_memslot_arbiter (
        .clk(clk), .rst_n(rst_n), .slot_cnt(slot_cnt), .line_cnt(line_cnt),
        .plane_cnt(plane_cnt), .hires(hires), .snd_en(snd_en), .spr_en(spr_en),
        .plane_en(plane_en), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .slot_owner(slot_owner), .cpu_ack(cpu_ack)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected DMA owner for the current inputs, from the requirements.
    function automatic logic [4:0] model();
        logic [4:0] o = '0;
        int s = slot_cnt;
        int l = line_cnt;
        int pos, pl, cnt;
        if (s % 2 == 1 && s <= 7) o[0] = 1'b1;
        else if (s % 2 == 1 && s >= 9 && s <= 15 && snd_en) o[1] = 1'b1;
        else if (s % 2 == 1 && s >= 17 && s <= 31 && spr_en) o[2] = 1'b1;
        else if (plane_en && l >= 26 && l <= 226 && s >= 56 && s <= 215) begin
            pos = (s - 56) % 8;
            if (!hires) begin
                if (pos % 2 == 1) pl = (pos + 1) / 2;
                else if (pos == 2) pl = 5;
                else if (pos == 6) pl = 6;
                else pl = 0;
                cnt = (plane_cnt > 6) ? 6 : int'(plane_cnt);
            end else begin
                pl  = ((pos >> 1) & 1) + ((pos % 2 == 1) ? 1 : 3);
                cnt = (plane_cnt > 4) ? 4 : int'(plane_cnt);
            end
            if (pl != 0 && pl <= cnt) o[3] = 1'b1;
        end
        return o;
    endfunction

    task automatic sweep(input string tag, input int first, input int last);
        logic [4:0] e;
        for (int s = first; s <= last; s++) begin
            slot_cnt = 8'(s);
            e = model();
            step();
            chk(tag, {cpu_ack, slot_owner}, {1'b0, e});
        end
    endtask

    task automatic t_reset();
        #5;
        chk("R11 reset", {cpu_ack, slot_owner}, 6'b0);
        cpu_req = 1'b1; cpu_addr = 24'hF00000;
        step();
        chk("R11 reset held", {cpu_ack, slot_owner}, 6'b0);
        cpu_req = 1'b0;
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_fixed();
        line_cnt = 9'd5; plane_en = 1'b1; plane_cnt = 3'd6;
        snd_en = 1'b1; spr_en = 1'b1;
        sweep("R2/R3 fixed enabled, R4 blank line", 0, 40);
        snd_en = 1'b0; spr_en = 1'b0;
        sweep("R3 fixed disabled", 0, 33);
        line_cnt = 9'd240; sweep("R4 bottom blanking", 56, 80);
    endtask

    task automatic t_lores();
        hires = 1'b0; line_cnt = 9'd100; plane_en = 1'b1;
        for (int p = 0; p <= 7; p++) begin
            plane_cnt = 3'(p);
            sweep("R5 lores pattern", 54, 73);
        end
        sweep("R4 window end", 210, 226);
        plane_en = 1'b0; sweep("R4 plane_en off", 56, 64);
    endtask

    task automatic t_hires();
        hires = 1'b1; line_cnt = 9'd26; plane_en = 1'b1;
        for (int p = 0; p <= 5; p++) begin
            plane_cnt = 3'(p);
            sweep("R6 hires pattern", 56, 71);
        end
        line_cnt = 9'd25; sweep("R4 line before window", 56, 63);
    endtask

    task automatic t_cpu_shared();
        hires = 1'b0; plane_cnt = 3'd6; plane_en = 1'b1; line_cnt = 9'd100;
        cpu_addr = 24'h001234; cpu_req = 1'b1;
        slot_cnt = 8'd57; step();
        chk("R8 blocked by plane 1", {cpu_ack, slot_owner}, 6'b001000);
        slot_cnt = 8'd58; step();
        chk("R8 blocked by plane 5", {cpu_ack, slot_owner}, 6'b001000);
        slot_cnt = 8'd60; step();
        chk("R7 granted in free slot", {cpu_ack, slot_owner}, 6'b110000);
        slot_cnt = 8'd61; step();
        chk("R10 no ack after grant", {cpu_ack, slot_owner}, 6'b001000);
        slot_cnt = 8'd64; step();
        chk("R10 regrant after two", {cpu_ack, slot_owner}, 6'b110000);
        slot_cnt = 8'd68; step();
        chk("R10 refused in ack cycle", {cpu_ack, slot_owner}, 6'b000000);
        cpu_req = 1'b0; step();
        chk("R7 idle after drop", {cpu_ack, slot_owner}, 6'b000000);
        line_cnt = 9'd3; slot_cnt = 8'd10; cpu_req = 1'b1; step();
        chk("R7 even slot in blanking", {cpu_ack, slot_owner}, 6'b110000);
        cpu_req = 1'b0; step();
    endtask

    task automatic t_cpu_ext();
        line_cnt = 9'd100; cpu_addr = 24'h080000; cpu_req = 1'b1;
        slot_cnt = 8'd1; step();
        chk("R9 ext ack in refresh slot", {cpu_ack, slot_owner}, 6'b100001);
        cpu_req = 1'b0; slot_cnt = 8'd57; step();
        chk("R9 ext done", {cpu_ack, slot_owner}, 6'b001000);
        cpu_addr = 24'hFC0000; cpu_req = 1'b1; slot_cnt = 8'd60; step();
        chk("R9 ext free slot no cpu owner", {cpu_ack, slot_owner}, 6'b100000);
        cpu_req = 1'b0; step();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fixed();
                t_lores();
                t_hires();
                t_cpu_shared();
                t_cpu_ext();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; fails++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                end
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule